// File: doc/BRIEF.md
# Pixel Memory Address Generator

This block sits between a shape plotter and a pixel writer in a raster graphics pipeline. It accepts 36-bit drawing commands, each qualified by a one-cycle strobe. The top four bits of a command select one of sixteen functions.

Setup functions do not pass down the pipeline. They load one of two raster descriptors, each holding a base address, a row pitch in bytes and a bitplane depth. The destination descriptor serves all write-type pixel functions. The source descriptor serves the read function.

Pixel functions carry X and Y coordinates. For each one, the block selects the descriptor that matches the function and computes the byte address of the pixel. For depths below one byte, it also computes the bit offset of the pixel inside that byte. It then emits a 36-bit pixel command with its own one-cycle strobe. Every other function is absorbed with no output.

Top module: `pxaddr_gen`

## Requirements
- R1: While reset is high, and in the cycle after it, `pixel_cmd_rdy` is 0. Reset clears `pixel_cmd` to zero. Reset also clears both descriptors, so base, pitch and depth code all read 0.
- R2: Function codes 1, 2, 3, 4 and 6 are pixel functions. A pixel function strobed in cycle n raises `pixel_cmd_rdy` in cycle n+2 for exactly one cycle, with the input function code copied to `pixel_cmd[35:32]`.
- R3: Codes 0, 5, 7, 8, 9, 10 and 11 never raise `pixel_cmd_rdy` and leave both descriptors unchanged. Codes 12 to 15 never raise `pixel_cmd_rdy` either.
- R4: Code 12 loads the destination pitch from input bits [15:0], and code 13 loads the source pitch from the same bits. Code 14 loads the destination base from bits [17:0] and the destination depth code from bits [26:24]. Code 15 does the same for the source.
- R5: Codes 1 to 4 use the destination descriptor. Code 6 uses the source descriptor.
- R6: X is taken from input bits [11:0] and Y from bits [23:12]. The output address in `pixel_cmd[17:0]` is base + Y×pitch + floor(X×bpp/8), taken modulo 2^18.
- R7: Depth codes 0, 1, 2, 3 and 4 mean 1, 2, 4, 8 and 16 bits per pixel, and codes 5 to 7 also mean 16 bits per pixel. `pixel_cmd[23:21]` carries the stored depth code. `pixel_cmd[20:18]` carries (X×bpp) mod 8, which is 0 at 8 and 16 bits per pixel.
- R8: `pixel_cmd[31:24]` carries input bits [31:24] for codes 1 and 2, and carries 0 for codes 3, 4 and 6.
- R9: A setup command takes effect for any pixel function strobed in a later cycle. A pixel function strobed one cycle before a setup command uses the old settings.
- R10: Pixel functions strobed in consecutive cycles each produce their own output, in consecutive cycles and in input order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| draw_cmd_rdy | input | 1 | One-cycle strobe qualifying `draw_cmd` |
| draw_cmd | input | 36 | Function code [35:32] and payload [31:0] |
| pixel_cmd_rdy | output | 1 | One-cycle strobe qualifying `pixel_cmd` |
| pixel_cmd | output | 36 | Function, colour, depth code, bit offset, byte address |

## Verification
Every pixel result is due two cycles after its input strobe. The bench drives inputs on falling edges and reads the output on the second falling edge after the strobe. It then reads once more on the next falling edge to confirm that the strobe has dropped.

For absorbed functions, the bench confirms that the strobe stays low in both of the following cycles. It then confirms that the descriptors are untouched by reading an address back through a later pixel function.

In the overlapping sequences, an output check and the next input drive share the same falling edge. This checks that a setup command issued right after a pixel function does not affect that pixel's address, and that back-to-back pixels come out in order.

// File: rtl/pxaddr_pkg.sv
package pxaddr_pkg;

    localparam int CMD_W        = 36;
    localparam int FN_W         = 4;
    localparam int COL_W        = 8;
    localparam int COORD_W      = 12;
    localparam int WID_W        = 16;
    localparam int ADDR_W       = 18;
    localparam int MODE_W       = 3;
    localparam int BITPOS_W     = 3;
    localparam int MAX_BPP_LOG2 = 4;
    localparam int MODE_LSB     = 24;

    localparam logic [FN_W-1:0] FN_WRITE     = 4'd1;
    localparam logic [FN_W-1:0] FN_WRITE_KEY = 4'd2;
    localparam logic [FN_W-1:0] FN_COPY      = 4'd3;
    localparam logic [FN_W-1:0] FN_COPY_KEY  = 4'd4;
    localparam logic [FN_W-1:0] FN_READ      = 4'd6;
    localparam logic [FN_W-1:0] FN_DST_PITCH = 4'd12;
    localparam logic [FN_W-1:0] FN_DST_BASE  = 4'd14;

    // one raster descriptor: where it starts, bytes per row, depth code
    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [WID_W-1:0]  pitch;
        logic [MODE_W-1:0] depth;
    } raster_t;

    // outgoing pixel command layout, msb first
    typedef struct packed {
        logic [FN_W-1:0]     fn;
        logic [COL_W-1:0]    colour;
        logic [MODE_W-1:0]   depth;
        logic [BITPOS_W-1:0] bitpos;
        logic [ADDR_W-1:0]   addr;
    } pixel_out_t;

    function automatic logic is_pixel_fn(input logic [FN_W-1:0] fn);
        return (fn == FN_WRITE) || (fn == FN_WRITE_KEY) || (fn == FN_COPY) ||
               (fn == FN_COPY_KEY) || (fn == FN_READ);
    endfunction

    function automatic logic keeps_colour(input logic [FN_W-1:0] fn);
        return (fn == FN_WRITE) || (fn == FN_WRITE_KEY);
    endfunction

    // log2 of bits per pixel; codes above the deepest mode saturate
    function automatic logic [2:0] depth_log2(input logic [MODE_W-1:0] depth);
        return (depth > MODE_W'(MAX_BPP_LOG2)) ? 3'(MAX_BPP_LOG2) : 3'(depth);
    endfunction

endpackage

// File: rtl/pxaddr_cfg.sv
module pxaddr_cfg
    import pxaddr_pkg::*;
#(
    parameter int SIDES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_vld,
    input  logic [FN_W-1:0]   cmd_fn,
    input  logic [WID_W-1:0]  pitch_in,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [MODE_W-1:0] depth_in,
    output raster_t           dst_ras,
    output raster_t           src_ras
);

    // side 0 = destination (codes 12/14), side 1 = source (codes 13/15)
    for (genvar i = 0; i < SIDES; i++) begin : g_side
        localparam logic [FN_W-1:0] PITCH_CODE = FN_DST_PITCH + FN_W'(i);
        localparam logic [FN_W-1:0] BASE_CODE  = FN_DST_BASE + FN_W'(i);
        raster_t ras_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                ras_q <= '0;
            end else if (cmd_vld) begin
                if (cmd_fn == PITCH_CODE) begin
                    ras_q.pitch <= pitch_in;
                end
                if (cmd_fn == BASE_CODE) begin
                    ras_q.base  <= base_in;
                    ras_q.depth <= depth_in;
                end
            end
        end
    end

    assign dst_ras = g_side[0].ras_q;
    assign src_ras = g_side[1].ras_q;

endmodule

// File: rtl/pxaddr_calc.sv
module pxaddr_calc
    import pxaddr_pkg::*;
(
    input  raster_t              ras,
    input  logic [COORD_W-1:0]   x,
    input  logic [COORD_W-1:0]   y,
    output logic [ADDR_W-1:0]    addr,
    output logic [BITPOS_W-1:0]  bitpos
);

    localparam int XBITS_W = COORD_W + MAX_BPP_LOG2;

    logic [XBITS_W-1:0] x_bits;
    logic [ADDR_W-1:0]  y_ext;
    logic [ADDR_W-1:0]  pitch_ext;
    logic [ADDR_W-1:0]  byte_off;

    always_comb begin
        x_bits    = XBITS_W'(x) << depth_log2(ras.depth);
        y_ext     = ADDR_W'(y);
        pitch_ext = ADDR_W'(ras.pitch);
        byte_off  = ADDR_W'(x_bits >> 3);
        addr      = ras.base + (y_ext * pitch_ext) + byte_off;
        bitpos    = x_bits[BITPOS_W-1:0];
    end

endmodule

// File: rtl/pxaddr_gen.sv
module pxaddr_gen
    import pxaddr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             draw_cmd_rdy,
    input  logic [CMD_W-1:0] draw_cmd,
    output logic             pixel_cmd_rdy,
    output logic [CMD_W-1:0] pixel_cmd
);

    logic [FN_W-1:0]    in_fn;
    logic [COL_W-1:0]   in_col;
    logic [COORD_W-1:0] in_x;
    logic [COORD_W-1:0] in_y;
    logic               in_pixel;

    assign in_fn    = draw_cmd[CMD_W-1 -: FN_W];
    assign in_col   = draw_cmd[CMD_W-FN_W-1 -: COL_W];
    assign in_y     = draw_cmd[2*COORD_W-1 -: COORD_W];
    assign in_x     = draw_cmd[COORD_W-1:0];
    assign in_pixel = draw_cmd_rdy && is_pixel_fn(in_fn);

    raster_t dst_ras;
    raster_t src_ras;

    pxaddr_cfg #(.SIDES(2)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .cmd_vld  (draw_cmd_rdy),
        .cmd_fn   (in_fn),
        .pitch_in (draw_cmd[WID_W-1:0]),
        .base_in  (draw_cmd[ADDR_W-1:0]),
        .depth_in (draw_cmd[MODE_LSB +: MODE_W]),
        .dst_ras  (dst_ras),
        .src_ras  (src_ras)
    );

    // stage 1: capture the pixel function with its descriptor
    logic               s1_vld;
    logic [FN_W-1:0]    s1_fn;
    logic [COL_W-1:0]   s1_col;
    logic [COORD_W-1:0] s1_x;
    logic [COORD_W-1:0] s1_y;
    raster_t            s1_ras;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_vld <= 1'b0;
            s1_fn  <= '0;
            s1_col <= '0;
            s1_x   <= '0;
            s1_y   <= '0;
            s1_ras <= '0;
        end else begin
            s1_vld <= in_pixel;
            if (in_pixel) begin
                s1_fn  <= in_fn;
                s1_col <= keeps_colour(in_fn) ? in_col : '0;
                s1_x   <= in_x;
                s1_y   <= in_y;
                s1_ras <= (in_fn == FN_READ) ? src_ras : dst_ras;
            end
        end
    end

    // stage 2: address arithmetic and output register
    logic [ADDR_W-1:0]   s1_addr;
    logic [BITPOS_W-1:0] s1_bitpos;

    pxaddr_calc u_calc (
        .ras    (s1_ras),
        .x      (s1_x),
        .y      (s1_y),
        .addr   (s1_addr),
        .bitpos (s1_bitpos)
    );

    pixel_out_t out_q;
    logic       out_vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld_q <= 1'b0;
            out_q     <= '0;
        end else begin
            out_vld_q <= s1_vld;
            if (s1_vld) begin
                out_q.fn     <= s1_fn;
                out_q.colour <= s1_col;
                out_q.depth  <= s1_ras.depth;
                out_q.bitpos <= s1_bitpos;
                out_q.addr   <= s1_addr;
            end
        end
    end

    assign pixel_cmd_rdy = out_vld_q;
    assign pixel_cmd     = out_q;

endmodule

// File: rtl/pxaddr_gen_chk.sv
module pxaddr_gen_chk (
    input logic        clk,
    input logic        rst,
    input logic        draw_cmd_rdy,
    input logic [35:0] draw_cmd,
    input logic        pixel_cmd_rdy,
    input logic [35:0] pixel_cmd
);

    logic in_pix;
    logic out_read_type;

    assign in_pix = draw_cmd_rdy &&
        ((draw_cmd[35:32] == 4'd1) || (draw_cmd[35:32] == 4'd2) ||
         (draw_cmd[35:32] == 4'd3) || (draw_cmd[35:32] == 4'd4) ||
         (draw_cmd[35:32] == 4'd6));
    assign out_read_type = (pixel_cmd[35:32] == 4'd3) ||
        (pixel_cmd[35:32] == 4'd4) || (pixel_cmd[35:32] == 4'd6);

    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        rst |=> !pixel_cmd_rdy);

    assert_pixel_latency_R2: assert property (@(posedge clk) disable iff (rst)
        in_pix |-> ##2 pixel_cmd_rdy);

    assert_fn_forwarded_R2: assert property (@(posedge clk) disable iff (rst)
        pixel_cmd_rdy |-> (pixel_cmd[35:32] == $past(draw_cmd[35:32], 2)));

    assert_absorbed_R3: assert property (@(posedge clk) disable iff (rst)
        (!in_pix) |-> ##2 !pixel_cmd_rdy);

    assert_byte_depth_offset_R7: assert property (@(posedge clk) disable iff (rst)
        (pixel_cmd_rdy && pixel_cmd[23:21] >= 3'd3) |-> (pixel_cmd[20:18] == 3'd0));

    assert_no_colour_on_copy_R8: assert property (@(posedge clk) disable iff (rst)
        (pixel_cmd_rdy && out_read_type) |-> (pixel_cmd[31:24] == 8'd0));

endmodule

bind pxaddr_gen pxaddr_gen_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .draw_cmd_rdy  (draw_cmd_rdy),
    .draw_cmd      (draw_cmd),
    .pixel_cmd_rdy (pixel_cmd_rdy),
    .pixel_cmd     (pixel_cmd)
);

// File: tb/pxaddr_gen_test.sv
module pxaddr_gen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_vld = 1'b0;
    logic [35:0] cmd = '0;
    logic        out_rdy;
    logic [35:0] out_cmd;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pxaddr_gen uut (
        .clk           (clk),
        .rst           (rst),
        .draw_cmd_rdy  (cmd_vld),
        .draw_cmd      (cmd),
        .pixel_cmd_rdy (out_rdy),
        .pixel_cmd     (out_cmd)
    );

    typedef struct packed {
        logic [3:0]  fn;
        logic [7:0]  col;
        logic [11:0] y;
        logic [11:0] x;
        logic [7:0]  ecol;
        logic [2:0]  emd;
        logic [2:0]  ebp;
        logic [17:0] eaddr;
    } vec_t;

    // dst: base 0x1000, pitch 320, depth 3 (8 bpp); src: base 0x20000, pitch 80, depth 2 (4 bpp)
    localparam vec_t VEC [8] = '{
        '{4'd1, 8'h5A, 12'd2,    12'd7,    8'h5A, 3'd3, 3'd0, 18'h01287},
        '{4'd2, 8'hFF, 12'd0,    12'd0,    8'hFF, 3'd3, 3'd0, 18'h01000},
        '{4'd3, 8'h77, 12'd1,    12'd319,  8'h00, 3'd3, 3'd0, 18'h0127F},
        '{4'd4, 8'h11, 12'd10,   12'd5,    8'h00, 3'd3, 3'd0, 18'h01C85},
        '{4'd6, 8'h33, 12'd3,    12'd5,    8'h00, 3'd2, 3'd4, 18'h200F2},
        '{4'd6, 8'h00, 12'd0,    12'd4095, 8'h00, 3'd2, 3'd4, 18'h207FF},
        '{4'd1, 8'h80, 12'd4095, 12'd4095, 8'h80, 3'd3, 3'd0, 18'h01EBF},
        '{4'd6, 8'h00, 12'd0,    12'd1,    8'h00, 3'd2, 3'd4, 18'h20000}
    };

    function automatic logic [35:0] pcmd(input logic [3:0] fn, input logic [7:0] col,
                                         input logic [11:0] y, input logic [11:0] x);
        return {fn, col, y, x};
    endfunction

    function automatic logic [35:0] pexp(input logic [3:0] fn, input logic [7:0] col,
                                         input logic [2:0] md, input logic [2:0] bp,
                                         input logic [17:0] addr);
        return {fn, col, md, bp, addr};
    endfunction

    task automatic check_out(input string req, input logic [35:0] exp);
        checks++;
        if (out_rdy !== 1'b1 || out_cmd !== exp) begin
            failures++;
            $display("FAIL %s: rdy=%b cmd=%h expected rdy=1 cmd=%h", req, out_rdy, out_cmd, exp);
        end
    endtask

    task automatic check_quiet(input string req);
        checks++;
        if (out_rdy !== 1'b0) begin
            failures++;
            $display("FAIL %s: rdy=%b expected rdy=0", req, out_rdy);
        end
    endtask

    // strobe one command; returns at the falling edge after the strobe
    task automatic drive(input logic [35:0] c);
        @(negedge clk);
        cmd_vld = 1'b1;
        cmd     = c;
        @(negedge clk);
        cmd_vld = 1'b0;
        cmd     = '0;
    endtask

    task automatic pixel(input string req, input logic [35:0] c, input logic [35:0] exp);
        drive(c);
        @(negedge clk);
        check_out(req, exp);
        @(negedge clk);
        check_quiet({req, " one-cycle strobe R2"});
    endtask

    // three strobes on consecutive cycles; output checks overlap the drives
    task automatic burst(input string req, input logic [35:0] c0, input logic [35:0] c1,
                         input logic [35:0] c2, input logic [35:0] e0,
                         input logic [35:0] e1, input logic [35:0] e2, input logic [2:0] ev);
        logic [35:0] cs [3];
        logic [35:0] es [3];
        cs[0] = c0; cs[1] = c1; cs[2] = c2;
        es[0] = e0; es[1] = e1; es[2] = e2;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (k >= 2) begin
                if (ev[k-2]) check_out(req, es[k-2]);
                else         check_quiet(req);
            end
            if (k < 3) begin
                cmd_vld = 1'b1;
                cmd     = cs[k];
            end else begin
                cmd_vld = 1'b0;
                cmd     = '0;
            end
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (out_rdy !== 1'b0 || out_cmd !== 36'h0) begin
            failures++;
            $display("FAIL R1: rdy=%b cmd=%h expected rdy=0 cmd=0", out_rdy, out_cmd);
        end
        rst = 1'b0;

        // R4 setup: pitches, bases and depth codes
        drive({4'd12, 16'h0, 16'd320});
        drive({4'd13, 16'h0, 16'd80});
        drive({4'd14, 8'd3, 24'h001000});
        drive({4'd15, 8'd2, 24'h020000});
        @(negedge clk);
        check_quiet("R3 setup commands give no strobe");

        // vector table: R5 R6 R7 R8
        for (int i = 0; i < 8; i++) begin
            pixel("R6 vector table", pcmd(VEC[i].fn, VEC[i].col, VEC[i].y, VEC[i].x),
                  pexp(VEC[i].fn, VEC[i].ecol, VEC[i].emd, VEC[i].ebp, VEC[i].eaddr));
        end

        // R7 depth codes on the source side: base 0, pitch 10, y 1, x 13
        drive({4'd13, 16'h0, 16'd10});
        drive({4'd15, 8'd0, 24'h0});
        pixel("R7 1bpp", pcmd(4'd6, 8'h00, 12'd1, 12'd13), pexp(4'd6, 8'h00, 3'd0, 3'd5, 18'd11));
        drive({4'd15, 8'd1, 24'h0});
        pixel("R7 2bpp", pcmd(4'd6, 8'h00, 12'd1, 12'd13), pexp(4'd6, 8'h00, 3'd1, 3'd2, 18'd13));
        drive({4'd15, 8'd2, 24'h0});
        pixel("R7 4bpp", pcmd(4'd6, 8'h00, 12'd1, 12'd13), pexp(4'd6, 8'h00, 3'd2, 3'd4, 18'd16));
        drive({4'd15, 8'd4, 24'h0});
        pixel("R7 16bpp", pcmd(4'd6, 8'h00, 12'd1, 12'd13), pexp(4'd6, 8'h00, 3'd4, 3'd0, 18'd36));
        drive({4'd15, 8'd7, 24'h0});
        pixel("R7 code 7 saturates", pcmd(4'd6, 8'h00, 12'd1, 12'd13), pexp(4'd6, 8'h00, 3'd7, 3'd0, 18'd36));

        // R3 absorbed codes, then prove descriptors were not touched
        begin
            logic [3:0] drop [7];
            drop = '{4'd0, 4'd5, 4'd7, 4'd8, 4'd9, 4'd10, 4'd11};
            for (int i = 0; i < 7; i++) begin
                drive({drop[i], 32'hFFFF_FFFF});
                @(negedge clk);
                check_quiet("R3 absorbed code");
                @(negedge clk);
                check_quiet("R3 absorbed code");
            end
        end
        pixel("R3 source unchanged", pcmd(4'd6, 8'h00, 12'd1, 12'd13), pexp(4'd6, 8'h00, 3'd7, 3'd0, 18'd36));
        pixel("R3 destination unchanged", pcmd(4'd1, 8'h42, 12'd0, 12'd3), pexp(4'd1, 8'h42, 3'd3, 3'd0, 18'h01003));

        // R9: pixel, base change, pixel
        burst("R9 setup ordering",
              pcmd(4'd1, 8'h01, 12'd0, 12'd2), {4'd14, 8'd3, 24'h002000}, pcmd(4'd1, 8'h02, 12'd0, 12'd2),
              pexp(4'd1, 8'h01, 3'd3, 3'd0, 18'h01002), 36'h0, pexp(4'd1, 8'h02, 3'd3, 3'd0, 18'h02002),
              3'b101);

        // R10: three pixels back to back
        burst("R10 back-to-back",
              pcmd(4'd2, 8'hA0, 12'd1, 12'd0), pcmd(4'd6, 8'hB0, 12'd0, 12'd2), pcmd(4'd4, 8'hC0, 12'd2, 12'd1),
              pexp(4'd2, 8'hA0, 3'd3, 3'd0, 18'h02140), pexp(4'd6, 8'h00, 3'd7, 3'd0, 18'd4),
              pexp(4'd4, 8'h00, 3'd3, 3'd0, 18'h02281), 3'b111);

        // R1: reset mid-run clears descriptors
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check_quiet("R1 during reset");
        rst = 1'b0;
        pixel("R1 descriptors cleared", pcmd(4'd1, 8'h09, 12'd5, 12'd9), pexp(4'd1, 8'h09, 3'd0, 3'd1, 18'd1));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule